// File: doc/BRIEF.md
# Residual Moving-Average Fault Detector

This block watches a pair of signed sample streams: one measured from a plant and one predicted by a model of that plant. On each accepted sample it forms the residual, measured minus predicted, which is near zero while the plant is healthy. The residual is smoothed by a moving average over a window of N samples, and a sticky alarm is raised once the magnitude of the smoothed value rises above a programmable threshold. Faults show up on the residual as a steady offset, a slow drift or a short burst.

The window length sets the balance between noise rejection and reaction time. A wide window suppresses random chatter, but the average climbs slowly after a step, so the alarm comes later. To measure this delay, a test-only onset strobe starts a cycle counter, and the counter stops on the cycle the alarm rises. Window length and threshold are captured by a load strobe while the stream is idle. The load also empties the filter.

Top module: `resid_avg_detector`

## Requirements
- R1: The residual of a sample is `meas - pred`, formed without overflow in DW+1 bits. With a window of one, `filt_res` equals that residual from the clock edge that accepts the sample.
- R2: `filt_res` is the sum of the most recent N residuals, or of all residuals since the last load if fewer have arrived, shifted arithmetically right by log2(N). Negative averages therefore round toward minus infinity (for example, -3 and 0 over N=2 give -2).
- R3: `cfg_win_log` selects N = 2^`cfg_win_log` for codes 0 to 6. Codes above the largest supported code are treated as that largest code.
- R4: The alarm sets on the edge that accepts a sample when the new average's magnitude is strictly greater than the threshold. Averages of either sign count, and a magnitude equal to the threshold does not set the alarm.
- R5: The alarm cannot set until N samples have been accepted since the last load, however large the residuals are.
- R6: Once set, the alarm stays high until `alarm_clr` is pulsed. The alarm is low after the edge that samples the clear, and a clear wins over a set in the same cycle.
- R7: `fault_onset` zeroes `lat_count` and starts it counting one per clock. The count freezes on the edge the alarm rises, so it holds the number of cycles from the onset edge to the alarm edge.
- R8: `cfg_load` captures the window code and threshold and empties the filter: the running sum and the sample count return to zero. The alarm is left unchanged.
- R9: During reset, `alarm`, `filt_valid`, `filt_res` and `lat_count` are all zero.
- R10: Cycles with `in_valid` low change neither `filt_res` nor the alarm, and `filt_valid` stays low. `filt_valid` is high in the cycle after each accepted sample.
- R11: For the same step fault and threshold, a longer window gives a larger `lat_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Capture configuration and empty the filter |
| cfg_win_log | input | 3 | Window code, N = 2^code |
| cfg_thresh | input | DW+1 | Unsigned alarm threshold on the average magnitude |
| in_valid | input | 1 | Sample pair present |
| meas | input | DW | Measured sample, signed |
| pred | input | DW | Predicted sample, signed |
| alarm_clr | input | 1 | Clear the sticky alarm |
| fault_onset | input | 1 | Test-only: start the latency counter |
| alarm | output | 1 | Sticky fault alarm |
| filt_valid | output | 1 | A new average was produced on the last edge |
| filt_res | output | DW+1 | Moving-average residual, signed |
| lat_count | output | LW | Cycles from onset to alarm rise |

## Verification
The hardest state to reach is a window that has just filled, with residuals already large enough to trip the threshold. Here only the sample count, not the data, decides whether the alarm sets. The stimulus first loads an eight-sample window and drives seven large residuals, which must leave the alarm low. It then drives the eighth, which must set the alarm. For the latency comparison, the window is filled with zero residuals before the onset strobe and step. This makes the delay depend only on how fast the average climbs through the window, so the counts for N=4 and N=16 can be computed exactly.

// File: rtl/resid_pkg.sv
package resid_pkg;
  localparam int WIN_CODE_W = 3;

  function automatic logic [WIN_CODE_W-1:0] clamp_win_code(
    input logic [WIN_CODE_W-1:0] code,
    input int unsigned           lim
  );
    logic [WIN_CODE_W-1:0] lim_c;
    lim_c = WIN_CODE_W'(lim);
    return (code > lim_c) ? lim_c : code;
  endfunction
endpackage

// File: rtl/resid_window.sv
module resid_window #(
  parameter int RW      = 17,
  parameter int MAX_LOG = 6,
  localparam int SW     = RW + MAX_LOG
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 push,
  input  logic signed [RW-1:0] res_in,
  input  logic [2:0]           win_log,
  output logic signed [SW-1:0] sum_q,
  output logic signed [SW-1:0] sum_nxt,
  output logic                 full_q,
  output logic                 full_nxt
);
  localparam int DEPTH = 1 << MAX_LOG;
  localparam int PW    = MAX_LOG;
  localparam int CW    = MAX_LOG + 1;

  logic signed [RW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d;
  logic [CW-1:0] fill_q, fill_d;
  logic [CW-1:0] win_n;
  logic [PW-1:0] mask;
  logic signed [RW-1:0] leaving;

  assign win_n   = CW'(1) << win_log;
  assign mask    = PW'(win_n - CW'(1));
  assign leaving = (fill_q == win_n) ? mem[wptr_q] : '0;

  always_comb begin
    wptr_d  = wptr_q;
    fill_d  = fill_q;
    sum_nxt = sum_q;
    if (flush) begin
      wptr_d  = '0;
      fill_d  = '0;
      sum_nxt = '0;
    end else if (push) begin
      sum_nxt = sum_q + SW'(res_in) - SW'(leaving);
      wptr_d  = (wptr_q + PW'(1)) & mask;
      fill_d  = (fill_q == win_n) ? fill_q : fill_q + CW'(1);
    end
  end

  assign full_nxt = (fill_d == win_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      fill_q <= '0;
      sum_q  <= '0;
      full_q <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      fill_q <= fill_d;
      sum_q  <= sum_nxt;
      full_q <= full_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wptr_q] <= res_in;
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= win_n) else $error("fill count beyond window"); // R5
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (sum_q == '0 && fill_q == '0)) else $error("flush left data"); // R8
endmodule

// File: rtl/resid_latency.sv
module resid_latency #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  output logic [LW-1:0] cnt_q
);
  logic          run_q, run_d;
  logic [LW-1:0] cnt_d;

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (start) begin
      cnt_d = '0;
      run_d = !stop;
    end else if (run_q) begin
      if (cnt_q != '1) cnt_d = cnt_q + LW'(1);
      if (stop) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/resid_avg_detector.sv
module resid_avg_detector
  import resid_pkg::*;
#(
  parameter int DW      = 16,
  parameter int MAX_LOG = 6,
  parameter int LW      = 16,
  localparam int RW     = DW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_load,
  input  logic [2:0]           cfg_win_log,
  input  logic [RW-1:0]        cfg_thresh,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] meas,
  input  logic signed [DW-1:0] pred,
  input  logic                 alarm_clr,
  input  logic                 fault_onset,
  output logic                 alarm,
  output logic                 filt_valid,
  output logic signed [RW-1:0] filt_res,
  output logic [LW-1:0]        lat_count
);
  localparam int SW = RW + MAX_LOG;

  logic [2:0]           wl_q, wl_d;
  logic [RW-1:0]        thr_q, thr_d;
  logic                 alarm_q, alarm_d, alarm_set, alarm_rise;
  logic                 fv_q, fv_d;
  logic                 push;
  logic signed [RW-1:0] resid;
  logic signed [SW-1:0] sum_q, sum_nxt, sh_q, sh_nxt;
  logic                 full_q, full_nxt;
  logic signed [RW-1:0] avg_nxt;
  logic [RW-1:0]        mag_nxt;

  assign push  = in_valid && !cfg_load;
  assign resid = $signed({meas[DW-1], meas}) - $signed({pred[DW-1], pred});

  resid_window #(.RW(RW), .MAX_LOG(MAX_LOG)) u_win (
    .clk(clk), .rst_n(rst_n), .flush(cfg_load), .push(push),
    .res_in(resid), .win_log(wl_q),
    .sum_q(sum_q), .sum_nxt(sum_nxt), .full_q(full_q), .full_nxt(full_nxt)
  );

  assign sh_nxt  = sum_nxt >>> wl_q;
  assign sh_q    = sum_q >>> wl_q;
  assign avg_nxt = sh_nxt[RW-1:0];
  assign mag_nxt = avg_nxt[RW-1] ? (~avg_nxt + RW'(1)) : avg_nxt;

  always_comb begin
    wl_d  = wl_q;
    thr_d = thr_q;
    if (cfg_load) begin
      wl_d  = clamp_win_code(cfg_win_log, MAX_LOG);
      thr_d = cfg_thresh;
    end
    alarm_set  = push && full_nxt && (mag_nxt > thr_q);
    alarm_d    = alarm_clr ? 1'b0 : (alarm_q | alarm_set);
    alarm_rise = alarm_set && !alarm_q && !alarm_clr;
    fv_d       = push;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wl_q    <= '0;
      thr_q   <= '1;
      alarm_q <= 1'b0;
      fv_q    <= 1'b0;
    end else begin
      wl_q    <= wl_d;
      thr_q   <= thr_d;
      alarm_q <= alarm_d;
      fv_q    <= fv_d;
    end
  end

  resid_latency #(.LW(LW)) u_lat (
    .clk(clk), .rst_n(rst_n), .start(fault_onset), .stop(alarm_rise),
    .cnt_q(lat_count)
  );

  assign alarm      = alarm_q;
  assign filt_valid = fv_q;
  assign filt_res   = sh_q[RW-1:0];

  AST_NO_EARLY_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_q) |-> full_q) else $error("alarm before window filled"); // R5
  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_q && !alarm_clr) |=> alarm_q) else $error("alarm dropped"); // R6
  AST_ALARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_clr |=> !alarm_q) else $error("clear ignored"); // R6
  AST_LAT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_q && !fault_onset) |=> $stable(lat_count)) else $error("latency moved"); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !cfg_load) |=> ($stable(filt_res) && !filt_valid)) else $error("idle changed output"); // R10
endmodule

// File: tb/resid_avg_detector_tb.sv
`timescale 1ns/1ps
module resid_avg_detector_tb;
  localparam int DW = 16;
  localparam int RW = DW + 1;
  localparam int LW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_load, in_valid, alarm_clr, fault_onset;
  logic [2:0] cfg_win_log;
  logic [RW-1:0] cfg_thresh;
  logic signed [DW-1:0] meas, pred;
  logic alarm, filt_valid;
  logic signed [RW-1:0] filt_res;
  logic [LW-1:0] lat_count;

  always #2.5 clk = ~clk;

  resid_avg_detector #(.DW(DW), .MAX_LOG(6), .LW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_win_log(cfg_win_log),
    .cfg_thresh(cfg_thresh), .in_valid(in_valid), .meas(meas), .pred(pred),
    .alarm_clr(alarm_clr), .fault_onset(fault_onset), .alarm(alarm),
    .filt_valid(filt_valid), .filt_res(filt_res), .lat_count(lat_count)
  );

  typedef struct { int filt; bit alm; string tag; } exp_t;
  exp_t sb[$];
  int hist[$];
  int n_chk = 0, n_bad = 0;
  int wl_m = 0, thr_m = 0, idx = 0, onset_idx = 0, exp_lat = 0;
  bit alarm_m = 0, lat_run = 0;
  int lat_a, lat_b;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic defaults();
    cfg_load = 0; in_valid = 0; alarm_clr = 0; fault_onset = 0;
    meas = 16'sd9999; pred = -16'sd9999;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); defaults(); end
  endtask

  task automatic load(int wl, int thr);
    @(negedge clk); defaults();
    cfg_load = 1; cfg_win_log = 3'(wl); cfg_thresh = RW'(thr);
    hist.delete(); wl_m = (wl > 6) ? 6 : wl; thr_m = thr;
  endtask

  task automatic clr();
    @(negedge clk); defaults(); alarm_clr = 1; alarm_m = 0;
  endtask

  task automatic sample(int m, int p, bit onset, string tag);
    int s, avg, mg;
    exp_t e;
    @(negedge clk); defaults();
    in_valid = 1; meas = DW'(m); pred = DW'(p); fault_onset = onset;
    hist.push_back(m - p);
    if (hist.size() > (1 << wl_m)) void'(hist.pop_front());
    s = 0;
    foreach (hist[i]) s += hist[i];
    avg = s >>> wl_m;
    mg = (avg < 0) ? -avg : avg;
    if (onset) begin onset_idx = idx; lat_run = 1; end
    if (hist.size() == (1 << wl_m) && mg > thr_m && !alarm_m) begin
      alarm_m = 1;
      if (lat_run) begin exp_lat = idx - onset_idx; lat_run = 0; end
    end
    e.filt = avg; e.alm = alarm_m; e.tag = tag;
    sb.push_back(e);
    idx++;
  endtask

  // monitor: pops one expected item per produced average
  always @(negedge clk) begin
    if (rst_n === 1'b1 && filt_valid === 1'b1) begin
      if (sb.size() == 0) check("R10 unexpected filt_valid", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " filt_res"}, int'(filt_res), e.filt);
        check({e.tag, " alarm"}, int'(alarm), int'(e.alm));
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    defaults(); cfg_win_log = 0; cfg_thresh = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R9 alarm", int'(alarm), 0);
    check("R9 filt_valid", int'(filt_valid), 0);
    check("R9 filt_res", int'(filt_res), 0);
    check("R9 lat_count", int'(lat_count), 0);
    rst_n = 1;

    // R1: window of one passes the residual through
    load(0, 1000);
    sample(50, 20, 0, "R1");
    sample(-7, 10, 0, "R1");
    sample(100, 100, 0, "R1");
    sample(-32768, 32767, 0, "R1");
    idle(1);
    clr();

    // R2: window four, mixed signs
    load(2, 100000);
    sample(4, 0, 0, "R2"); sample(8, 0, 0, "R2"); sample(0, 3, 0, "R2");
    sample(-20, 0, 0, "R2"); sample(5, 0, 0, "R2"); sample(1, 2, 0, "R2");
    // R3: window two, negative rounds toward minus infinity; code 7 acts as 6
    load(1, 100000);
    sample(-3, 0, 0, "R3"); sample(0, 0, 0, "R3");
    // R10: idle cycles with garbage inputs
    idle(4);
    check("R10 filt_res held", int'(filt_res), -2);
    check("R10 filt_valid low", int'(filt_valid), 0);
    check("R10 alarm low", int'(alarm), 0);
    load(7, 100000);
    for (int k = 0; k < 70; k++) sample(k, 0, 0, "R3");
    idle(1);

    // R5 then R4: seven big samples no alarm, eighth sets it
    load(3, 10);
    for (int k = 0; k < 7; k++) sample(1000, 0, 0, "R5");
    sample(1000, 0, 0, "R4");
    // R6: sticky while small residuals keep coming
    for (int k = 0; k < 4; k++) sample(0, 0, 0, "R6");
    clr();
    idle(1);
    check("R6 cleared", int'(alarm), 0);

    // R4: negative average, strict comparison at equality
    load(0, 5);
    sample(0, 5, 0, "R4");
    sample(0, 6, 0, "R4");
    idle(1);
    // R6: clear wins over simultaneous set
    @(negedge clk); defaults(); alarm_clr = 1; in_valid = 1; meas = 100; pred = 0;
    alarm_m = 0; hist.delete(); hist.push_back(100);
    sb.push_back('{100, 1'b0, "R6"});
    idle(1);
    check("R6 clear priority", int'(alarm), 0);

    // R8: load empties filter, alarm untouched
    load(2, 100);
    sample(500, 0, 0, "R8"); sample(500, 0, 0, "R8"); sample(500, 0, 0, "R8");
    sample(500, 0, 0, "R8");
    load(2, 100);
    idle(1);
    check("R8 sum emptied", int'(filt_res), 0);
    check("R8 alarm kept", int'(alarm), 1);
    sample(200, 0, 0, "R8"); sample(200, 0, 0, "R8");
    sample(200, 0, 0, "R8"); sample(200, 0, 0, "R8");
    idle(1);
    clr();

    // R7 / R11: step fault latency for N=4 and N=16
    load(2, 50);
    for (int k = 0; k < 4; k++) sample(0, 0, 0, "R7");
    sample(100, 0, 1, "R7");
    for (int k = 0; k < 11; k++) sample(100, 0, 0, "R7");
    idle(2);
    check("R7 latency N=4", int'(lat_count), exp_lat);
    check("R7 latency N=4 value", int'(lat_count), 2);
    lat_a = int'(lat_count);
    clr();
    load(4, 50);
    for (int k = 0; k < 16; k++) sample(0, 0, 0, "R11");
    sample(100, 0, 1, "R11");
    for (int k = 0; k < 11; k++) sample(100, 0, 0, "R11");
    idle(2);
    check("R7 latency N=16", int'(lat_count), 8);
    lat_b = int'(lat_count);
    check("R11 longer window slower", int'(lat_b > lat_a), 1);
    clr();
    idle(2);
    check("R9 scoreboard drained", sb.size(), 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule